// File: doc/BRIEF.md
# Threshold-Triggered FIFO Burst Engine

This block feeds and drains the two data FIFOs of a serial controller with 64-bit words taken from memory and sent back to it. Software programs a start address for each direction, a fill-level threshold and a burst length for each FIFO, and a burst count for each direction. It then sets the enable bit. The engine watches the FIFO levels.

When the transmit FIFO holds fewer words than its threshold, the engine reads one burst of words from memory and pushes them into that FIFO. When the receive FIFO holds more words than its threshold, the engine pops one burst and writes it to memory. Each direction keeps its own address pointer and its own count of bursts still to do. Only one burst is in flight at a time.

Once every enabled direction has finished its bursts, the engine pulses a completion output and clears its own enable. Software polls the enable bit to learn that the segment is done and can then program the next one. The memory port carries one word per accepted request. Read data returns on a separate valid strobe.

Top module: `fifo_burst_dma`

## Requirements
- R1: After reset the control word (address 0) reads with the enable bit 0 clear, the transmit threshold field (bits 13:8) at 0, the receive threshold field (bits 21:16) at 31 and both length fields at 0. No memory request is made and the completion output is low.
- R2: A read burst starts only while the engine is enabled, the read counter is enabled and has bursts left, and the transmit level is strictly below the transmit threshold. A level equal to the threshold starts nothing.
- R3: A write burst starts only while the engine is enabled, the write counter is enabled and has bursts left, and the receive level is strictly above the receive threshold. A level equal to the threshold starts nothing.
- R4: Burst lengths are programmed as length minus one: the read length in control bits 26:24 and the write length in bits 30:28. A burst moves exactly that many words plus one. A length field of 0 never starts a burst.
- R5: Every read response of a read burst is pushed into the transmit FIFO, in the order it returns, with the returned data. Each write word is taken from the head of the receive FIFO, and that word is popped in the same cycle its write request is granted.
- R6: Each direction's address starts at its start register (read at address 1, write at address 2) and advances by 8 for each granted word, carrying on across bursts. Both pointers are reloaded each time the enable bit is set.
- R7: Burst counts are programmed at address 3, the read count in bits 15:0 and the write count in bits 31:16. The counter enables are at address 4, bit 0 for read and bit 1 for write. A direction whose counter enable is clear makes no bursts and counts as finished.
- R8: When the engine is idle and every enabled direction has no bursts left, the completion output is high for exactly one cycle and the enable bit reads 0 from then on. This also holds when neither direction is enabled.
- R9: When both directions are due in the same cycle, the write burst goes first. Read and write bursts never overlap.
- R10: A write to the control word while the engine is enabled changes no field. Writing it with bit 0 clear stops the engine without a completion pulse.
- R11: The start-address, count and counter-enable registers read back the values last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 3 | Register address |
| cfg_wdata_i | input | 32 | Register write data |
| cfg_rdata_o | output | 32 | Register read data for cfg_addr_i |
| tx_level_i | input | 6 | Words held in the transmit FIFO |
| tx_push_o | output | 1 | Push strobe into the transmit FIFO |
| tx_data_o | output | 64 | Word pushed into the transmit FIFO |
| rx_level_i | input | 6 | Words held in the receive FIFO |
| rx_pop_o | output | 1 | Pop strobe from the receive FIFO |
| rx_data_i | input | 64 | Head word of the receive FIFO |
| mem_req_o | output | 1 | Memory request valid |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | 32 | Byte address of the word |
| mem_wdata_o | output | 64 | Write data |
| mem_gnt_i | input | 1 | Request accepted this cycle |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 64 | Read data |
| done_o | output | 1 | One-cycle pulse when all programmed bursts are complete |

## Verification
Faults in the internal state show up at the ports in different ways.

- A stale or mis-stepped address pointer is visible on the very next granted request, because the address on the memory port jumps by something other than 8 or fails to restart at the start register after a new enable.
- A wrong word counter inside a burst shows up as a burst one word short or long. A wrong burst counter shows up as the wrong number of bursts. Either way, the request total differs once the completion pulse arrives.
- A wrong threshold comparison or a wrong burst-count state shows up as a request that appears, or never appears, within a few cycles of a level change.
- A completion state that lingers shows up as a pulse wider than one cycle.

// File: rtl/fbd_pkg.sv
package fbd_pkg;
  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_RD = 2'd1, ST_WR = 2'd2} fbd_state_e;

  localparam logic [2:0] REG_CTRL     = 3'd0;
  localparam logic [2:0] REG_RD_START = 3'd1;
  localparam logic [2:0] REG_WR_START = 3'd2;
  localparam logic [2:0] REG_COUNTS   = 3'd3;
  localparam logic [2:0] REG_CNT_EN   = 3'd4;

  localparam int CTRL_TXTHR_LSB = 8;
  localparam int CTRL_RXTHR_LSB = 16;
  localparam int CTRL_RDLEN_LSB = 24;
  localparam int CTRL_WRLEN_LSB = 28;
  localparam int COUNTS_WR_LSB  = 16;
endpackage

// File: rtl/fbd_cfg_regs.sv
module fbd_cfg_regs
  import fbd_pkg::*;
#(
  parameter int AW         = 32,
  parameter int LW         = 6,
  parameter int LENW       = 3,
  parameter int CW         = 16,
  parameter int RX_THR_RST = 31
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [2:0]      addr_i,
  input  logic [31:0]     wdata_i,
  input  logic            fin_i,
  output logic            en_o,
  output logic            en_set_o,
  output logic [LW-1:0]   tx_thr_o,
  output logic [LW-1:0]   rx_thr_o,
  output logic [LENW-1:0] rd_m1_o,
  output logic [LENW-1:0] wr_m1_o,
  output logic [AW-1:0]   rd_start_o,
  output logic [AW-1:0]   wr_start_o,
  output logic [CW-1:0]   rd_cnt_o,
  output logic [CW-1:0]   wr_cnt_o,
  output logic            rd_cen_o,
  output logic            wr_cen_o,
  output logic [31:0]     rdata_o
);
  logic ctrl_wr;
  assign ctrl_wr  = we_i && (addr_i == REG_CTRL);
  assign en_set_o = ctrl_wr && !en_o && wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o       <= 1'b0;
      tx_thr_o   <= '0;
      rx_thr_o   <= LW'(RX_THR_RST);
      rd_m1_o    <= '0;
      wr_m1_o    <= '0;
      rd_start_o <= '0;
      wr_start_o <= '0;
      rd_cnt_o   <= '0;
      wr_cnt_o   <= '0;
      rd_cen_o   <= 1'b0;
      wr_cen_o   <= 1'b0;
    end else begin
      if (fin_i) begin
        en_o <= 1'b0;
      end else if (ctrl_wr) begin
        if (!en_o) begin
          en_o     <= wdata_i[0];
          tx_thr_o <= wdata_i[CTRL_TXTHR_LSB +: LW];
          rx_thr_o <= wdata_i[CTRL_RXTHR_LSB +: LW];
          rd_m1_o  <= wdata_i[CTRL_RDLEN_LSB +: LENW];
          wr_m1_o  <= wdata_i[CTRL_WRLEN_LSB +: LENW];
        end else if (!wdata_i[0]) begin
          en_o <= 1'b0;  // abort; fields stay frozen while running
        end
      end
      if (we_i && addr_i == REG_RD_START) rd_start_o <= wdata_i[AW-1:0];
      if (we_i && addr_i == REG_WR_START) wr_start_o <= wdata_i[AW-1:0];
      if (we_i && addr_i == REG_COUNTS) begin
        rd_cnt_o <= wdata_i[CW-1:0];
        wr_cnt_o <= wdata_i[COUNTS_WR_LSB +: CW];
      end
      if (we_i && addr_i == REG_CNT_EN) begin
        rd_cen_o <= wdata_i[0];
        wr_cen_o <= wdata_i[1];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      REG_CTRL: begin
        rdata_o[0]                     = en_o;
        rdata_o[CTRL_TXTHR_LSB +: LW]  = tx_thr_o;
        rdata_o[CTRL_RXTHR_LSB +: LW]  = rx_thr_o;
        rdata_o[CTRL_RDLEN_LSB +: LENW] = rd_m1_o;
        rdata_o[CTRL_WRLEN_LSB +: LENW] = wr_m1_o;
      end
      REG_RD_START: rdata_o[AW-1:0] = rd_start_o;
      REG_WR_START: rdata_o[AW-1:0] = wr_start_o;
      REG_COUNTS: begin
        rdata_o[CW-1:0]              = rd_cnt_o;
        rdata_o[COUNTS_WR_LSB +: CW] = wr_cnt_o;
      end
      REG_CNT_EN: rdata_o[1:0] = {wr_cen_o, rd_cen_o};
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/fbd_dir_track.sv
module fbd_dir_track #(
  parameter int AW         = 32,
  parameter int CW         = 16,
  parameter int WORD_BYTES = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] start_i,
  input  logic [CW-1:0] count_i,
  input  logic          cen_i,
  input  logic          beat_i,
  input  logic          burst_done_i,
  output logic [AW-1:0] ptr_o,
  output logic          fin_o
);
  logic [CW-1:0] left_q;
  logic          cen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_o  <= '0;
      left_q <= '0;
      cen_q  <= 1'b0;
    end else if (load_i) begin
      ptr_o  <= start_i;
      left_q <= count_i;
      cen_q  <= cen_i;
    end else begin
      if (beat_i) ptr_o <= ptr_o + AW'(WORD_BYTES);
      if (burst_done_i && left_q != '0) left_q <= left_q - CW'(1);
    end
  end

  assign fin_o = !cen_q || (left_q == '0);
endmodule

// File: rtl/fbd_burst_fsm.sv
module fbd_burst_fsm
  import fbd_pkg::*;
#(
  parameter int LENW = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            go_rd_i,
  input  logic            go_wr_i,
  input  logic [LENW-1:0] rd_m1_i,
  input  logic [LENW-1:0] wr_m1_i,
  input  logic            mem_gnt_i,
  input  logic            mem_rvalid_i,
  output logic            mem_req_o,
  output logic            mem_we_o,
  output logic            rd_beat_o,
  output logic            wr_beat_o,
  output logic            rd_done_o,
  output logic            wr_done_o,
  output logic            tx_push_o,
  output logic            rx_pop_o,
  output logic            idle_o
);
  localparam int BW = LENW + 1;

  fbd_state_e    st_q;
  logic [BW-1:0] len_q, iss_q, ret_q;

  always_comb begin
    mem_req_o = 1'b0;
    mem_we_o  = 1'b0;
    rd_beat_o = 1'b0;
    wr_beat_o = 1'b0;
    rd_done_o = 1'b0;
    wr_done_o = 1'b0;
    tx_push_o = 1'b0;
    rx_pop_o  = 1'b0;
    case (st_q)
      ST_RD: begin
        mem_req_o = iss_q < len_q;
        rd_beat_o = mem_req_o && mem_gnt_i;
        tx_push_o = mem_rvalid_i;
        rd_done_o = mem_rvalid_i && (ret_q + BW'(1) == len_q);
      end
      ST_WR: begin
        mem_req_o = 1'b1;
        mem_we_o  = 1'b1;
        wr_beat_o = mem_gnt_i;
        rx_pop_o  = mem_gnt_i;
        wr_done_o = mem_gnt_i && (iss_q + BW'(1) == len_q);
      end
      default: ;
    endcase
  end

  assign idle_o = (st_q == ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      len_q <= '0;
      iss_q <= '0;
      ret_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          iss_q <= '0;
          ret_q <= '0;
          if (en_i && go_wr_i) begin  // drain side first
            st_q  <= ST_WR;
            len_q <= BW'(wr_m1_i) + BW'(1);
          end else if (en_i && go_rd_i) begin
            st_q  <= ST_RD;
            len_q <= BW'(rd_m1_i) + BW'(1);
          end
        end
        ST_RD: begin
          if (rd_beat_o) iss_q <= iss_q + BW'(1);
          if (mem_rvalid_i) ret_q <= ret_q + BW'(1);
          if (rd_done_o) st_q <= ST_IDLE;
        end
        ST_WR: begin
          if (wr_beat_o) iss_q <= iss_q + BW'(1);
          if (wr_done_o) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fifo_burst_dma.sv
module fifo_burst_dma
  import fbd_pkg::*;
#(
  parameter int AW         = 32,
  parameter int DW         = 64,
  parameter int FIFO_DEPTH = 32,
  parameter int MAX_BURST  = 8,
  parameter int CW         = 16,
  parameter int RX_THR_RST = 31
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            cfg_we_i,
  input  logic [2:0]                      cfg_addr_i,
  input  logic [31:0]                     cfg_wdata_i,
  output logic [31:0]                     cfg_rdata_o,
  input  logic [$clog2(FIFO_DEPTH+1)-1:0] tx_level_i,
  output logic                            tx_push_o,
  output logic [DW-1:0]                   tx_data_o,
  input  logic [$clog2(FIFO_DEPTH+1)-1:0] rx_level_i,
  output logic                            rx_pop_o,
  input  logic [DW-1:0]                   rx_data_i,
  output logic                            mem_req_o,
  output logic                            mem_we_o,
  output logic [AW-1:0]                   mem_addr_o,
  output logic [DW-1:0]                   mem_wdata_o,
  input  logic                            mem_gnt_i,
  input  logic                            mem_rvalid_i,
  input  logic [DW-1:0]                   mem_rdata_i,
  output logic                            done_o
);
  localparam int LW         = $clog2(FIFO_DEPTH + 1);
  localparam int LENW       = $clog2(MAX_BURST);
  localparam int WORD_BYTES = DW / 8;

  logic            en_q, en_set, fin;
  logic [LW-1:0]   tx_thr, rx_thr;
  logic [LENW-1:0] rd_m1, wr_m1;
  logic [AW-1:0]   rd_start, wr_start, rd_ptr, wr_ptr;
  logic [CW-1:0]   rd_cnt, wr_cnt;
  logic            rd_cen, wr_cen, rd_fin, wr_fin;
  logic            rd_beat, wr_beat, rd_done, wr_done, idle;
  logic            go_rd, go_wr;

  fbd_cfg_regs #(
    .AW(AW), .LW(LW), .LENW(LENW), .CW(CW), .RX_THR_RST(RX_THR_RST)
  ) u_regs (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i), .fin_i(fin),
    .en_o(en_q), .en_set_o(en_set),
    .tx_thr_o(tx_thr), .rx_thr_o(rx_thr), .rd_m1_o(rd_m1), .wr_m1_o(wr_m1),
    .rd_start_o(rd_start), .wr_start_o(wr_start),
    .rd_cnt_o(rd_cnt), .wr_cnt_o(wr_cnt), .rd_cen_o(rd_cen), .wr_cen_o(wr_cen),
    .rdata_o(cfg_rdata_o)
  );

  fbd_dir_track #(.AW(AW), .CW(CW), .WORD_BYTES(WORD_BYTES)) u_rd_trk (
    .clk_i, .rst_ni, .load_i(en_set), .start_i(rd_start), .count_i(rd_cnt),
    .cen_i(rd_cen), .beat_i(rd_beat), .burst_done_i(rd_done),
    .ptr_o(rd_ptr), .fin_o(rd_fin)
  );

  fbd_dir_track #(.AW(AW), .CW(CW), .WORD_BYTES(WORD_BYTES)) u_wr_trk (
    .clk_i, .rst_ni, .load_i(en_set), .start_i(wr_start), .count_i(wr_cnt),
    .cen_i(wr_cen), .beat_i(wr_beat), .burst_done_i(wr_done),
    .ptr_o(wr_ptr), .fin_o(wr_fin)
  );

  // a one-word burst never qualifies
  assign go_rd = !rd_fin && (rd_m1 != '0) && (tx_level_i < tx_thr);
  assign go_wr = !wr_fin && (wr_m1 != '0) && (rx_level_i > rx_thr);

  fbd_burst_fsm #(.LENW(LENW)) u_fsm (
    .clk_i, .rst_ni, .en_i(en_q), .go_rd_i(go_rd), .go_wr_i(go_wr),
    .rd_m1_i(rd_m1), .wr_m1_i(wr_m1),
    .mem_gnt_i, .mem_rvalid_i,
    .mem_req_o, .mem_we_o,
    .rd_beat_o(rd_beat), .wr_beat_o(wr_beat), .rd_done_o(rd_done), .wr_done_o(wr_done),
    .tx_push_o, .rx_pop_o, .idle_o(idle)
  );

  assign fin         = en_q && idle && rd_fin && wr_fin;
  assign done_o      = fin;
  assign mem_addr_o  = mem_we_o ? wr_ptr : rd_ptr;
  assign mem_wdata_o = rx_data_i;
  assign tx_data_o   = mem_rdata_i;
endmodule

// File: rtl/fbd_checker.sv
module fbd_checker #(
  parameter int AW         = 32,
  parameter int WORD_BYTES = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          en_i,
  input logic          mem_req_i,
  input logic          mem_we_i,
  input logic          mem_gnt_i,
  input logic [AW-1:0] mem_addr_i,
  input logic          tx_push_i,
  input logic          rx_pop_i,
  input logic          done_i
);
  a_r2_start_needs_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_req_i) |-> $past(en_i));

  a_r5_pop_on_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_pop_i |-> (mem_req_i && mem_we_i && mem_gnt_i));

  a_r6_addr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_i && mem_gnt_i) |=>
      (!(mem_req_i && (mem_we_i == $past(mem_we_i))) ||
       mem_addr_i == $past(mem_addr_i) + AW'(WORD_BYTES)));

  a_r8_done_clears_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !en_i);

  a_r8_done_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> !mem_req_i);

  a_r9_one_dir: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({tx_push_i, rx_pop_i}));
endmodule

bind fifo_burst_dma fbd_checker #(.AW(AW), .WORD_BYTES(DW / 8)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_q),
  .mem_req_i(mem_req_o), .mem_we_i(mem_we_o), .mem_gnt_i(mem_gnt_i),
  .mem_addr_i(mem_addr_o), .tx_push_i(tx_push_o), .rx_pop_i(rx_pop_o),
  .done_i(done_o)
);

// File: tb/fifo_burst_dma_bench.sv
module fifo_burst_dma_bench;
  import fbd_pkg::*;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n;
  logic        cfg_we;
  logic [2:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic [5:0]  tx_level, rx_level;
  logic        tx_push, rx_pop;
  logic [63:0] tx_data, rx_data;
  logic        mem_req, mem_we, mem_gnt, mem_rvalid, done;
  logic [31:0] mem_addr;
  logic [63:0] mem_wdata, mem_rdata;

  assign mem_gnt = mem_req;

  fifo_burst_dma u_fifo_burst_dma (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata),
    .tx_level_i(tx_level), .tx_push_o(tx_push), .tx_data_o(tx_data),
    .rx_level_i(rx_level), .rx_pop_o(rx_pop), .rx_data_i(rx_data),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_gnt_i(mem_gnt), .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
    .done_o(done)
  );

  int vecs = 0, fails = 0;
  int wr_n, rd_n, push_n, pop_n, done_n, first_we;
  logic [31:0] wr_addr [64];
  logic [63:0] wr_data [64];
  logic [31:0] rd_addr [64];
  logic [63:0] push_data [64];
  logic        pend;
  logic [63:0] pend_data;

  function automatic logic [63:0] rd_pat(input logic [31:0] a);
    return {~a, a};
  endfunction
  function automatic logic [63:0] rx_pat(input int n);
    return 64'hC0DE_0000_0000_0000 | 64'(n);
  endfunction
  function automatic logic [31:0] mk_ctrl(input bit en, input int txt, input int rxt,
                                          input int rdm1, input int wrm1);
    return 32'(en) | (32'(txt) << 8) | (32'(rxt) << 16) | (32'(rdm1) << 24) | (32'(wrm1) << 28);
  endfunction

  // memory / FIFO model: drive at negedge, sample just before posedge
  initial begin
    pend = 0; pend_data = '0; mem_rvalid = 0; mem_rdata = '0;
    wr_n = 0; rd_n = 0; push_n = 0; pop_n = 0; done_n = 0; first_we = -1;
    rx_data = rx_pat(0);
    forever begin
      @(negedge clk);
      mem_rvalid = pend;
      mem_rdata  = pend_data;
      rx_data    = rx_pat(pop_n);
      #4;
      if (rst_n) begin
        if (mem_req && mem_gnt) begin
          if (first_we < 0) first_we = int'(mem_we);
          if (mem_we) begin
            if (wr_n < 64) begin wr_addr[wr_n] = mem_addr; wr_data[wr_n] = mem_wdata; end
            wr_n++;
          end else begin
            if (rd_n < 64) rd_addr[rd_n] = mem_addr;
            rd_n++;
          end
        end
        pend      = mem_req && mem_gnt && !mem_we;
        pend_data = rd_pat(mem_addr);
        if (tx_push) begin
          if (push_n < 64) push_data[push_n] = tx_data;
          push_n++;
        end
        if (rx_pop) pop_n++;
        if (done) done_n++;
      end else begin
        pend = 0;
      end
    end
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog (all reqs): actual hung expected completion");
    summary();
    $finish;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    vecs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = a;
    #2 d = cfg_rdata;
  endtask

  task automatic clear_logs();
    @(negedge clk);
    wr_n = 0; rd_n = 0; push_n = 0; first_we = -1;
  endtask

  task automatic run(input logic [31:0] ctrl, input int max, output int pulses);
    int d0;
    d0 = done_n;
    reg_wr(REG_CTRL, ctrl);
    for (int i = 0; i < max; i++) begin
      @(negedge clk);
      if (done_n != d0) break;
    end
    repeat (4) @(negedge clk);
    pulses = done_n - d0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    reg_rd(REG_CTRL, d);
    chk("R1 ctrl reset", 64'(d), 64'(mk_ctrl(0, 0, 31, 0, 0)));
    chk("R1 no request", 64'(mem_req), 64'd0);
    chk("R1 done low", 64'(done), 64'd0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    reg_wr(REG_RD_START, 32'h1234_5678);
    reg_rd(REG_RD_START, d);  chk("R11 rd start", 64'(d), 64'h1234_5678);
    reg_wr(REG_WR_START, 32'h0BAD_F00D);
    reg_rd(REG_WR_START, d);  chk("R11 wr start", 64'(d), 64'h0BAD_F00D);
    reg_wr(REG_COUNTS, 32'hABCD_0123);
    reg_rd(REG_COUNTS, d);    chk("R7 R11 counts halves", 64'(d), 64'hABCD_0123);
    reg_wr(REG_CNT_EN, 32'h3);
    reg_rd(REG_CNT_EN, d);    chk("R7 R11 counter enables", 64'(d), 64'h3);
  endtask

  task automatic t_tx_run();
    int p; logic [31:0] d;
    clear_logs();
    tx_level = 0; rx_level = 0;
    reg_wr(REG_RD_START, 32'h1000);
    reg_wr(REG_COUNTS, 32'h0000_0003);
    reg_wr(REG_CNT_EN, 32'h1);
    run(mk_ctrl(1, 29, 31, 3, 0), 200, p);
    chk("R8 one done pulse (tx)", 64'(p), 64'd1);
    chk("R4 R7 read words 3x4", 64'(rd_n), 64'd12);
    chk("R5 pushes", 64'(push_n), 64'd12);
    chk("R7 no writes", 64'(wr_n), 64'd0);
    for (int k = 0; k < 12; k++) begin
      chk("R6 read addr", 64'(rd_addr[k]), 64'(32'h1000 + 32'(8 * k)));
      chk("R5 push data", push_data[k], rd_pat(32'h1000 + 32'(8 * k)));
    end
    reg_rd(REG_CTRL, d);
    chk("R8 enable self-cleared", 64'(d[0]), 64'd0);
  endtask

  task automatic t_rx_run();
    int p, base;
    clear_logs();
    base = pop_n;
    tx_level = 6'd40; rx_level = 6'd5;
    reg_wr(REG_WR_START, 32'h2000);
    reg_wr(REG_COUNTS, 32'h0002_0000);
    reg_wr(REG_CNT_EN, 32'h2);
    run(mk_ctrl(1, 0, 1, 0, 1), 200, p);
    chk("R8 one done pulse (rx)", 64'(p), 64'd1);
    chk("R4 write words 2x2", 64'(wr_n), 64'd4);
    chk("R5 pops", 64'(pop_n - base), 64'd4);
    for (int k = 0; k < 4; k++) begin
      chk("R6 write addr", 64'(wr_addr[k]), 64'(32'h2000 + 32'(8 * k)));
      chk("R5 write data from rx head", wr_data[k], rx_pat(base + k));
    end
  endtask

  task automatic t_thresholds();
    int p; logic [31:0] d;
    clear_logs();
    tx_level = 6'd29; rx_level = 0;
    reg_wr(REG_RD_START, 32'h4000);
    reg_wr(REG_COUNTS, 32'h0000_0001);
    reg_wr(REG_CNT_EN, 32'h1);
    reg_wr(REG_CTRL, mk_ctrl(1, 29, 31, 1, 0));
    repeat (20) @(negedge clk);
    chk("R2 level equal to threshold: no read", 64'(rd_n), 64'd0);
    reg_rd(REG_CTRL, d);
    chk("R2 still enabled", 64'(d[0]), 64'd1);
    tx_level = 6'd28;
    for (int i = 0; i < 100 && done_n == 0; i++) @(negedge clk);
    repeat (20) @(negedge clk);
    chk("R2 level below threshold: read burst", 64'(rd_n), 64'd2);
    clear_logs();
    p = done_n;
    tx_level = 6'd40; rx_level = 6'd1;
    reg_wr(REG_WR_START, 32'h5000);
    reg_wr(REG_COUNTS, 32'h0001_0000);
    reg_wr(REG_CNT_EN, 32'h2);
    reg_wr(REG_CTRL, mk_ctrl(1, 0, 1, 0, 1));
    repeat (20) @(negedge clk);
    chk("R3 level equal to threshold: no write", 64'(wr_n), 64'd0);
    rx_level = 6'd2;
    repeat (30) @(negedge clk);
    chk("R3 level above threshold: write burst", 64'(wr_n), 64'd2);
    chk("R8 done after rx threshold run", 64'(done_n - p), 64'd1);
  endtask

  task automatic t_len1_abort();
    int p; logic [31:0] d;
    clear_logs();
    p = done_n;
    tx_level = 0; rx_level = 0;
    reg_wr(REG_COUNTS, 32'h0000_0001);
    reg_wr(REG_CNT_EN, 32'h1);
    reg_wr(REG_CTRL, mk_ctrl(1, 29, 31, 0, 0));
    repeat (20) @(negedge clk);
    chk("R4 length field 0 never bursts", 64'(rd_n), 64'd0);
    reg_wr(REG_CTRL, mk_ctrl(1, 5, 7, 3, 3));
    reg_rd(REG_CTRL, d);
    chk("R10 fields frozen while enabled", 64'(d), 64'(mk_ctrl(1, 29, 31, 0, 0)));
    reg_wr(REG_CTRL, mk_ctrl(0, 5, 7, 3, 3));
    reg_rd(REG_CTRL, d);
    chk("R10 abort clears enable only", 64'(d), 64'(mk_ctrl(0, 29, 31, 0, 0)));
    repeat (5) @(negedge clk);
    chk("R10 abort gives no done pulse", 64'(done_n - p), 64'd0);
  endtask

  task automatic t_priority();
    int p;
    clear_logs();
    tx_level = 0; rx_level = 6'd20;
    reg_wr(REG_RD_START, 32'h6000);
    reg_wr(REG_WR_START, 32'h7000);
    reg_wr(REG_COUNTS, 32'h0001_0001);
    reg_wr(REG_CNT_EN, 32'h3);
    run(mk_ctrl(1, 29, 3, 1, 1), 200, p);
    chk("R9 write burst first", 64'(first_we), 64'd1);
    chk("R9 writes", 64'(wr_n), 64'd2);
    chk("R9 reads", 64'(rd_n), 64'd2);
    chk("R8 single done with both", 64'(p), 64'd1);
  endtask

  task automatic t_disabled_dir();
    int p;
    clear_logs();
    tx_level = 0; rx_level = 6'd20;
    reg_wr(REG_RD_START, 32'h8000);
    reg_wr(REG_COUNTS, 32'h0005_0001);
    reg_wr(REG_CNT_EN, 32'h1);
    run(mk_ctrl(1, 29, 3, 1, 1), 200, p);
    chk("R7 disabled write counter: no writes", 64'(wr_n), 64'd0);
    chk("R7 read side runs", 64'(rd_n), 64'd2);
    chk("R7 done with disabled side", 64'(p), 64'd1);
  endtask

  task automatic t_none_enabled();
    int p;
    clear_logs();
    reg_wr(REG_CNT_EN, 32'h0);
    run(mk_ctrl(1, 29, 3, 1, 1), 10, p);
    chk("R8 empty run completes once", 64'(p), 64'd1);
    chk("R8 empty run makes no request", 64'(rd_n + wr_n), 64'd0);
  endtask

  task automatic t_reload();
    int p;
    tx_level = 0; rx_level = 0;
    reg_wr(REG_RD_START, 32'h3000);
    reg_wr(REG_COUNTS, 32'h0000_0001);
    reg_wr(REG_CNT_EN, 32'h1);
    for (int r = 0; r < 2; r++) begin
      clear_logs();
      run(mk_ctrl(1, 29, 31, 1, 0), 100, p);
      chk("R6 pointer reloaded on enable", 64'(rd_addr[0]), 64'h3000);
      chk("R6 second word", 64'(rd_addr[1]), 64'h3008);
    end
  endtask

  initial begin
    rst_n = 0; cfg_we = 0; cfg_addr = '0; cfg_wdata = '0;
    tx_level = 0; rx_level = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_regs();
    t_tx_run();
    t_rx_run();
    t_thresholds();
    t_len1_abort();
    t_priority();
    t_disabled_dir();
    t_none_enabled();
    t_reload();
    repeat (5) @(negedge clk);
    summary();
    $finish;
  end
endmodule